// File: doc/BRIEF.md
# ChaCha20 Keystream Block Generator

This block turns a 256-bit key and a 64-bit block counter into ChaCha20 keystream. The nonce is fixed at zero. A single start pulse captures the key, the first counter value and how many 64-byte blocks to make. The block then produces that many consecutive blocks with no further help from the caller. Each block leaves as sixteen 32-bit words on a valid/ready stream. Once the run is over, the block shows the advanced counter, so the caller can continue the sequence later, and it pulses a completion flag.

The permutation core computes four quarter-rounds side by side in every cycle. Even cycles work on the columns of the 4x4 state and odd cycles work on the diagonals, so the core needs twenty cycles for one block. The stream follows the usual valid/ready rules. Data moves only in a cycle where `ks_valid_o` and `ks_ready_i` are both high. While a word is offered and not yet taken, both the word and `ks_valid_o` stay unchanged. The consumer can hold `ks_ready_i` low for as long as it likes. Stalling only pauses the stream, because the rounds for the next block begin only after the last word of the current block has been taken. When the run finishes, the block wipes its copy of the key and its working state.

Top module: `chacha_keystream`

## Requirements
- R1: The starting state of a block uses words 0..3 = 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574. Words 4..11 hold key words 0..7, where key word i is `key_i[32*i+31:32*i]`. Word 12 holds counter bits 31:0, word 13 holds counter bits 63:32, and words 14 and 15 are zero.
- R2: Each output block is the starting state after ten double rounds, added word by word (mod 2^32) to the starting state. One double round is a column round followed by a diagonal round. Each quarter-round uses rotations 16, 12, 8 and 7.
- R3: A block goes out as words 0 to 15 in that order, one word per accepted handshake. Within each word the least significant byte is keystream byte 0, so with an all-zero key and counter, word 0 has low byte 0x76.
- R4: While `ks_valid_o` is high and `ks_ready_i` is low, `ks_valid_o` and `ks_data_o` stay unchanged on the next cycle.
- R5: Block k of a run, counting from 0, uses counter `ctr_i + k` mod 2^64. The carry passes from word 12 into word 13, and all ones wraps to zero.
- R6: A run with count N produces exactly N blocks. After that, `ks_valid_o` stays low.
- R7: `done_o` goes high for exactly one cycle, in the cycle after the last word is accepted. From that cycle on, `busy_o` is low and `ctr_o` equals `ctr_i + N` mod 2^64. `ctr_o` keeps that value until the next run starts.
- R8: `busy_o` goes high in the cycle after an accepted start and stays high until `done_o`. A start that arrives while `busy_o` is high is ignored.
- R9: A start with `nblk_i` = 0 is ignored: `busy_o`, `ks_valid_o` and `ctr_o` do not change.
- R10: `ks_valid_o` first rises 20 cycles after the start is accepted. After each block except the last, `ks_valid_o` rises again 20 cycles after the final handshake of that block.
- R11: In the cycle where `done_o` is high, the stored key and the working state are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only when idle and the count is nonzero |
| key_i | input | 256 | Key; word i at bits 32*i+31:32*i |
| ctr_i | input | 64 | Counter value for the first block |
| nblk_i | input | NB_W | Number of blocks to produce |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| ctr_o | output | 64 | Counter value after the last run |
| ks_valid_o | output | 1 | A keystream word is offered |
| ks_ready_i | input | 1 | The consumer takes the offered word |
| ks_data_o | output | 32 | Keystream word |

## Verification
The bench compares every output word against a behavioural model of the cipher. That model is checked in turn against the known all-zero-key keystream. A core that swaps diagonal lanes, forgets to undo a rotation or skips the feed-forward addition therefore fails on the first word. Two counter cases are aimed at the carry. In one, the low word rolls over into the high word; a design that loses this carry repeats a block or jumps back to counter 0. In the other, the full 64-bit counter wraps to zero. The bench applies random back-pressure to catch words that are dropped or change during a stall. It issues a second start in the middle of a run, which would corrupt the stream if it were not ignored. It also issues a zero-length start, which would launch a run of 2^NB_W blocks if it were not rejected.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 16;
  localparam int KEY_W   = 256;
  localparam int CTR_W   = 64;
  localparam int WIDX_W  = $clog2(N_WORDS);

  localparam int ROT_A = 16;
  localparam int ROT_B = 12;
  localparam int ROT_C = 8;
  localparam int ROT_D = 7;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ROUND = 2'd1,
    PH_EMIT  = 2'd2
  } phase_e;

  function automatic word_t sigma_word(input int idx);
    case (idx)
      0:       return 32'h61707865;
      1:       return 32'h3320646e;
      2:       return 32'h79622d32;
      default: return 32'h6b206574;
    endcase
  endfunction

  function automatic state_t build_state(input logic [KEY_W-1:0] key,
                                         input logic [CTR_W-1:0] ctr);
    state_t s;
    for (int i = 0; i < 4; i++) s[i] = sigma_word(i);
    for (int i = 0; i < 8; i++) s[4+i] = key[WORD_W*i +: WORD_W];
    s[12] = ctr[31:0];
    s[13] = ctr[63:32];
    s[14] = '0;
    s[15] = '0;
    return s;
  endfunction

  function automatic word_t rotl(input word_t v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;
  word_t a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, ROT_A);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, ROT_B);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, ROT_C);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, ROT_D);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/chacha_round.sv
module chacha_round
  import chacha_pkg::*;
(
  input  state_t st_i,
  input  logic   diag_i,
  output state_t st_o
);
  localparam int LANES = 4;

  word_t qa [LANES];
  word_t qb [LANES];
  word_t qc [LANES];
  word_t qd [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int B_COL = 4 + g;
    localparam int C_COL = 8 + g;
    localparam int D_COL = 12 + g;
    localparam int B_DIA = 4 + ((g + 1) % LANES);
    localparam int C_DIA = 8 + ((g + 2) % LANES);
    localparam int D_DIA = 12 + ((g + 3) % LANES);

    word_t b_in, c_in, d_in;
    assign b_in = diag_i ? st_i[B_DIA] : st_i[B_COL];
    assign c_in = diag_i ? st_i[C_DIA] : st_i[C_COL];
    assign d_in = diag_i ? st_i[D_DIA] : st_i[D_COL];

    chacha_qr u_qr (
      .a_i (st_i[g]),
      .b_i (b_in),
      .c_i (c_in),
      .d_i (d_in),
      .a_o (qa[g]),
      .b_o (qb[g]),
      .c_o (qc[g]),
      .d_o (qd[g])
    );
  end

  always_comb begin
    st_o = st_i;
    for (int g = 0; g < LANES; g++) begin
      st_o[g] = qa[g];
      if (diag_i) begin
        st_o[4  + ((g + 1) % LANES)] = qb[g];
        st_o[8  + ((g + 2) % LANES)] = qc[g];
        st_o[12 + ((g + 3) % LANES)] = qd[g];
      end else begin
        st_o[4  + g] = qb[g];
        st_o[8  + g] = qc[g];
        st_o[12 + g] = qd[g];
      end
    end
  end
endmodule

// File: rtl/chacha_seq.sv
module chacha_seq
  import chacha_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              ready_i,
  input  logic              last_i,
  output phase_e            phase_o,
  output logic              diag_o,
  output logic              round_en_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic              blk_end_o,
  output logic              run_end_o
);
  localparam int RND_W = $clog2(ROUNDS);
  localparam logic [RND_W-1:0]  RND_LAST  = RND_W'(ROUNDS - 1);
  localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(N_WORDS - 1);

  phase_e            phase_q;
  logic [RND_W-1:0]  rnd_q;
  logic [WIDX_W-1:0] widx_q;
  logic              hs;

  assign hs         = (phase_q == PH_EMIT) && ready_i;
  assign blk_end_o  = hs && (widx_q == WIDX_LAST);
  assign run_end_o  = blk_end_o && last_i;
  assign round_en_o = (phase_q == PH_ROUND);
  assign diag_o     = rnd_q[0];
  assign phase_o    = phase_q;
  assign widx_o     = widx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
      widx_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (go_i) begin
            phase_q <= PH_ROUND;
            rnd_q   <= '0;
          end
        end
        PH_ROUND: begin
          rnd_q <= rnd_q + 1'b1;
          if (rnd_q == RND_LAST) begin
            phase_q <= PH_EMIT;
            widx_q  <= '0;
          end
        end
        PH_EMIT: begin
          if (hs) begin
            widx_q <= widx_q + 1'b1;
            if (widx_q == WIDX_LAST) begin
              phase_q <= last_i ? PH_IDLE : PH_ROUND;
              rnd_q   <= '0;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chacha_keystream.sv
module chacha_keystream
  import chacha_pkg::*;
#(
  parameter int NB_W   = 16,
  parameter int ROUNDS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [CTR_W-1:0]  ctr_i,
  input  logic [NB_W-1:0]   nblk_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CTR_W-1:0]  ctr_o,
  output logic              ks_valid_o,
  input  logic              ks_ready_i,
  output logic [WORD_W-1:0] ks_data_o
);
  logic [KEY_W-1:0]  key_q;
  logic [CTR_W-1:0]  ctr_q;
  logic [NB_W-1:0]   left_q;
  state_t            work_q;
  logic              done_q;

  phase_e            phase;
  logic              diag, round_en, blk_end, run_end, go, last_blk;
  logic [WIDX_W-1:0] widx;
  state_t            round_out;
  state_t            init_cur;
  logic [CTR_W-1:0]  ctr_next;

  assign go       = start_i && (phase == PH_IDLE) && (nblk_i != '0);
  assign last_blk = (left_q == NB_W'(1));
  assign ctr_next = ctr_q + CTR_W'(1);
  assign init_cur = build_state(key_q, ctr_q);

  chacha_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go),
    .ready_i    (ks_ready_i),
    .last_i     (last_blk),
    .phase_o    (phase),
    .diag_o     (diag),
    .round_en_o (round_en),
    .widx_o     (widx),
    .blk_end_o  (blk_end),
    .run_end_o  (run_end)
  );

  chacha_round u_round (
    .st_i   (work_q),
    .diag_i (diag),
    .st_o   (round_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      ctr_q  <= '0;
      left_q <= '0;
      work_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_end;
      if (go) begin
        key_q  <= key_i;
        ctr_q  <= ctr_i;
        left_q <= nblk_i;
        work_q <= build_state(key_i, ctr_i);
      end else if (round_en) begin
        work_q <= round_out;
      end else if (blk_end) begin
        ctr_q  <= ctr_next;
        left_q <= left_q - NB_W'(1);
        if (run_end) begin
          key_q  <= '0;
          work_q <= '0;
        end else begin
          work_q <= build_state(key_q, ctr_next);
        end
      end
    end
  end

  assign busy_o     = (phase != PH_IDLE);
  assign done_o     = done_q;
  assign ctr_o      = ctr_q;
  assign ks_valid_o = (phase == PH_EMIT);
  assign ks_data_o  = work_q[widx] + init_cur[widx];
endmodule

// File: rtl/chacha_keystream_chk.sv
module chacha_keystream_chk #(
  parameter int NB_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [NB_W-1:0]  nblk_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             ks_valid_o,
  input logic             ks_ready_i,
  input logic [31:0]      ks_data_o,
  input logic [255:0]     key_q,
  input logic [511:0]     work_q
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid_o && !ks_ready_i) |=> (ks_valid_o && $stable(ks_data_o)));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !ks_valid_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid_o |-> busy_o);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (nblk_i == '0)) |=> !busy_o);

  // R10
  first_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !ks_valid_o);

  // R11
  wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((key_q == '0) && (work_q == '0)));
endmodule

bind chacha_keystream chacha_keystream_chk #(.NB_W(NB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .nblk_i     (nblk_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ks_valid_o (ks_valid_o),
  .ks_ready_i (ks_ready_i),
  .ks_data_o  (ks_data_o),
  .key_q      (key_q),
  .work_q     (work_q)
);

// File: tb/tb_chacha_keystream.sv
`timescale 1ns/1ps
module tb_chacha_keystream;
  localparam int NB_W = 16;

  typedef struct packed {
    logic [255:0] key;
    logic [63:0]  ctr;
    logic [7:0]   n;
    logic [1:0]   mode;   // 0 always ready, 1 random stall, 2 start mid-run
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{256'h0,                      64'h0,                   8'd1, 2'd0},
    '{{4{64'h0123456789abcdef}},   64'h1,                   8'd2, 2'd1},
    '{{8{32'h9e3779b9}},           64'h00000000_ffffffff,   8'd3, 2'd0},
    '{{2{128'h00112233_44556677_8899aabb_ccddeeff}}, 64'hffffffff_ffffffff, 8'd2, 2'd1},
    '{{8{32'h5a5a_c3c3}},          64'h5,                   8'd3, 2'd2}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [255:0]     key_i = '0;
  logic [63:0]      ctr_i = '0;
  logic [NB_W-1:0]  nblk_i = '0;
  logic             busy_o, done_o, ks_valid_o;
  logic             ks_ready_i = 1'b0;
  logic [63:0]      ctr_o;
  logic [31:0]      ks_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hace1;

  always #2 clk = ~clk;

  chacha_keystream #(.NB_W(NB_W)) dut (
    .clk, .rst_n, .start_i, .key_i, .ctr_i, .nblk_i,
    .busy_o, .done_o, .ctr_o, .ks_valid_o, .ks_ready_i, .ks_data_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [127:0] quarter(input logic [31:0] a, b, c, d);
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
    return {a, b, c, d};
  endfunction

  function automatic logic [511:0] model_block(input logic [255:0] k,
                                               input logic [63:0] c);
    logic [31:0] s [16];
    logic [31:0] x [16];
    logic [511:0] r;
    s[0] = 32'h61707865; s[1] = 32'h3320646e;
    s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    s[12] = c[31:0]; s[13] = c[63:32]; s[14] = '0; s[15] = '0;
    x = s;
    for (int r2 = 0; r2 < 10; r2++) begin
      {x[0], x[4], x[8],  x[12]} = quarter(x[0], x[4], x[8],  x[12]);
      {x[1], x[5], x[9],  x[13]} = quarter(x[1], x[5], x[9],  x[13]);
      {x[2], x[6], x[10], x[14]} = quarter(x[2], x[6], x[10], x[14]);
      {x[3], x[7], x[11], x[15]} = quarter(x[3], x[7], x[11], x[15]);
      {x[0], x[5], x[10], x[15]} = quarter(x[0], x[5], x[10], x[15]);
      {x[1], x[6], x[11], x[12]} = quarter(x[1], x[6], x[11], x[12]);
      {x[2], x[7], x[8],  x[13]} = quarter(x[2], x[7], x[8],  x[13]);
      {x[3], x[4], x[9],  x[14]} = quarter(x[3], x[4], x[9],  x[14]);
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
    return r;
  endfunction

  task automatic run_vec(input vec_t v);
    logic [511:0] exp;
    bit stalled = 1'b0;
    logic [31:0] held = '0;
    bit sent = 1'b0;
    @(negedge clk);
    key_i = v.key; ctr_i = v.ctr; nblk_i = NB_W'(v.n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R8 busy after start", 64'(busy_o), 64'd1);
    for (int b = 0; b < int'(v.n); b++) begin
      int gap = 0;
      exp = model_block(v.key, v.ctr + 64'(b));
      while (!ks_valid_o && gap < 100) begin
        gap++;
        ks_ready_i = 1'b0;
        @(negedge clk);
      end
      chk(gap == 20, "R10 rounds latency", 64'(gap), 64'd20);
      for (int w = 0; w < 16; ) begin
        if (v.mode == 2'd2 && b == 0 && w == 5 && !sent) begin
          start_i = 1'b1; key_i = ~v.key; nblk_i = NB_W'(1); sent = 1'b1;
        end else begin
          start_i = 1'b0;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ks_ready_i = (v.mode == 2'd1) ? (lfsr[0] | lfsr[3]) : 1'b1;
        if (stalled)
          chk(ks_valid_o && ks_data_o == held, "R4 stall hold",
              64'(ks_data_o), 64'(held));
        stalled = ks_valid_o && !ks_ready_i;
        held = ks_data_o;
        if (ks_valid_o && ks_ready_i) begin
          chk(ks_data_o == exp[32*w +: 32], (b == 0) ? "R2 word" : "R5 word",
              64'(ks_data_o), 64'(exp[32*w +: 32]));
          w++;
        end
        @(negedge clk);
      end
      stalled = 1'b0;
    end
    start_i = 1'b0;
    ks_ready_i = 1'b0;
    chk(done_o, "R7 done pulse", 64'(done_o), 64'd1);
    chk(!busy_o && !ks_valid_o, "R6 run over", {62'd0, busy_o, ks_valid_o}, 64'd0);
    chk(ctr_o == v.ctr + 64'(v.n), "R7 counter out", ctr_o, v.ctr + 64'(v.n));
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", 64'(done_o), 64'd0);
    chk(!ks_valid_o, "R6 no extra block", 64'(ks_valid_o), 64'd0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [511:0] kat;
    logic [63:0] last_ctr;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !ks_valid_o && ctr_o == 0, "R7 reset state",
        {busy_o, done_o, ks_valid_o, ctr_o[60:0]}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    kat = model_block('0, '0);
    chk(kat[31:0]   == 32'hade0b876, "R1 zero-key word 0", 64'(kat[31:0]),   64'hade0b876);
    chk(kat[63:32]  == 32'h903df1a0, "R1 zero-key word 1", 64'(kat[63:32]),  64'h903df1a0);
    chk(kat[95:64]  == 32'he56a5d40, "R1 zero-key word 2", 64'(kat[95:64]),  64'he56a5d40);
    chk(kat[127:96] == 32'h28bd8653, "R1 zero-key word 3", 64'(kat[127:96]), 64'h28bd8653);

    for (int i = 0; i < 5; i++) run_vec(VECS[i]);

    // R3: byte order and first word of the zero-key block
    @(negedge clk);
    key_i = '0; ctr_i = '0; nblk_i = NB_W'(1); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ks_ready_i = 1'b1;
    for (int t = 0; t < 40 && !ks_valid_o; t++) @(negedge clk);
    chk(ks_data_o[7:0] == 8'h76, "R3 first byte", 64'(ks_data_o[7:0]), 64'h76);
    while (busy_o) @(negedge clk);
    ks_ready_i = 1'b0;
    @(negedge clk);
    last_ctr = ctr_o;
    chk(last_ctr == 64'd1, "R7 counter after zero-key run", last_ctr, 64'd1);

    // R9: zero count
    key_i = {8{32'h1234abcd}}; ctr_i = 64'h77; nblk_i = '0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o && !ks_valid_o, "R9 zero count busy", {62'd0, busy_o, ks_valid_o}, 64'd0);
    repeat (25) @(negedge clk);
    chk(!ks_valid_o && ctr_o == last_ctr, "R9 zero count state", ctr_o, last_ctr);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule